// File: doc/BRIEF.md
# Five-Channel Down-Counting Interval Timer

This block is a timer peripheral with five independent down-counters behind a small memory-mapped register port (byte address, 32-bit write data, write strobe, combinational read data). Each counter takes a single-cycle tick that comes from two shared 8-bit prescalers and a divider select for each channel. The whole block therefore runs in one clock domain. Software loads a count buffer, and a compare buffer for channels 0 to 3. It then holds the channel in manual-update mode so the live counter and compare register copy the buffers. Finally it releases manual update and sets start. In that state the counter decrements once per tick.

A channel with auto-reload set is periodic: after reaching zero it reloads from its buffer on the next tick and keeps running. With auto-reload clear the channel is one-shot and stays at zero. The transition of a counter to zero sets a sticky status flag for that channel. The flag drives that channel's own interrupt line when its enable bit is set. Each channel also drives a level output taken from a compare between the counter and the compare register, which software can invert. Software reads the live count from an observation register for each channel.

Top module: `dct_timer`

## Requirements
- R1: Reset clears every register, counter, compare register and status flag, so all counters stop, every read returns 0, and `irq` and `pwm_out` are low.
- R2: Address map. 0x00 holds the prescalers (bits 15:0). 0x04 holds the divider selects (bits 19:0). 0x08 is control. 0x44 holds the interrupt enables (bits 4:0) and status flags (bits 9:5). The count buffer of channel n is at 0x0C+12n and the compare buffer of channels 0 to 3 is at 0x10+12n, both CNT_W bits wide. All of these registers read back what was written, and unlisted addresses read 0.
- R3: Prescaler field 0 (bits 7:0) feeds channels 0 and 1, and field 1 (bits 15:8) feeds channels 2 to 4. A field value p yields one prescaler pulse every p+1 clocks.
- R4: The divider select of channel n sits at bits 4n+3:4n. A code c passes one prescaler pulse in 2^(c+DIV_BASE), with the exponent capped at 4 (divide by 16).
- R5: Control bit positions. Channel 0 uses bits 3:0, and channel n≥1 uses bits 4n+7:4n+4, laid out as start (+0), manual update (+1), invert (+2) and auto-reload (+3). Channel 4 has no invert and its auto-reload is bit 22. Bits 7:4 and bits 31:23 read 0 and affect nothing.
- R6: While manual update is set, the counter and compare register copy their buffers on every clock and no counting takes place.
- R7: With start set and manual update clear, each tick decrements a nonzero counter. On a tick at zero, a channel with auto-reload copies its count buffer (and compare buffer) again, giving a period of buffer+1 ticks. Without auto-reload the counter holds at zero.
- R8: The observation register at 0x14+12n (channels 0 to 3) and at 0x40 (channel 4) returns the live counter value.
- R9: A channel's status flag sets when its counter decrements from 1 to 0. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A new set wins over a clear in the same cycle.
- R10: `irq[n]` is high exactly when status flag n and enable bit n are both set.
- R11: `pwm_out[n]` is high while the counter exceeds the compare register, XOR the invert bit. Channel 4 has no compare buffer: its compare value is 0 and it never inverts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 5 | Interrupt line for each channel |
| pwm_out | output | 5 | Compare-based level for each channel |

## Verification
The hardest thing to reach from the ports is the exact tick phase of a channel. That phase depends on the free-running prescaler and divider counters, which have been running since reset and are shared across channels, so no single write puts them in a known state. The bench keeps its own behavioural copy of those counters, advances it on every clock and predicts every tick. Its observation reads and its per-cycle comparison of `irq` and `pwm_out` can then land on the exact cycle of a reload or a transition to zero. This holds across several prescaler and divider settings, including the capped divider code.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int NCH  = 5;
    localparam int NGRP = 2;
    localparam int DIVW = 4;

    localparam logic [7:0] A_CFG0 = 8'h00;
    localparam logic [7:0] A_CFG1 = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_INT  = 8'h44;

    typedef struct packed {
        logic reload;
        logic invert;
        logic manual;
        logic start;
    } chctl_t;

    function automatic int grp_of(int n);
        return (n < 2) ? 0 : 1;
    endfunction

    function automatic int ctl_base(int n);
        return (n == 0) ? 0 : 4 * (n + 1);
    endfunction

    function automatic logic [7:0] cntb_addr(int n);
        return 8'(12 + 12 * n);
    endfunction

    function automatic logic [7:0] cmpb_addr(int n);
        return 8'(16 + 12 * n);
    endfunction

    function automatic logic [7:0] obs_addr(int n);
        return (n == NCH - 1) ? 8'h40 : 8'(20 + 12 * n);
    endfunction

    // mask of divider-counter bits that must all be one for a tick
    function automatic logic [DIVW-1:0] div_mask(logic [3:0] code, int base);
        int sh;
        sh = int'(code) + base;
        if (sh > DIVW) sh = DIVW;
        return DIVW'((1 << sh) - 1);
    endfunction

    function automatic chctl_t ctl_unpack(logic [31:0] w, int n);
        chctl_t c;
        int b;
        b = ctl_base(n);
        c.start  = w[b];
        c.manual = w[b+1];
        c.invert = (n < NCH - 1) ? w[b+2] : 1'b0;
        c.reload = (n < NCH - 1) ? w[b+3] : w[b+2];
        return c;
    endfunction

    function automatic logic [31:0] ctl_pack(chctl_t c, int n);
        logic [31:0] w;
        int b;
        w = '0;
        b = ctl_base(n);
        w[b]   = c.start;
        w[b+1] = c.manual;
        if (n < NCH - 1) begin
            w[b+2] = c.invert;
            w[b+3] = c.reload;
        end else begin
            w[b+2] = c.reload;
        end
        return w;
    endfunction
endpackage

// File: rtl/dct_prescale.sv
module dct_prescale #(
    parameter int PW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] scale,
    output logic          pulse,
    output logic [DW-1:0] divcnt
);
    logic [PW-1:0] cnt_q;

    assign pulse = (cnt_q >= scale);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            divcnt <= '0;
        end else if (pulse) begin
            cnt_q  <= '0;
            divcnt <= divcnt + 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  chctl_t           ctl,
    input  logic [CNT_W-1:0] cntb,
    input  logic [CNT_W-1:0] cmpb,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_evt,
    output logic             pwm
);
    logic [CNT_W-1:0] cmp_q;
    logic             run;

    assign run      = ctl.start && !ctl.manual && tick;
    assign zero_evt = run && (cnt == CNT_W'(1));
    assign pwm      = (cnt > cmp_q) ^ ctl.invert;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cmp_q <= '0;
        end else if (ctl.manual) begin
            cnt   <= cntb;
            cmp_q <= cmpb;
        end else if (run) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (ctl.reload) begin
                cnt   <= cntb;
                cmp_q <= cmpb;
            end
        end
    end
endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import dct_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_BASE = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     addr,
    input  logic [31:0]    wdata,
    input  logic           we,
    output logic [31:0]    rdata,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] pwm_out
);
    logic [NGRP-1:0][7:0]       pre_q;
    logic [NCH-1:0][3:0]        dsel_q;
    chctl_t [NCH-1:0]           ctl_q;
    logic [NCH-1:0][CNT_W-1:0]  cntb_q;
    logic [NCH-1:0][CNT_W-1:0]  cmpb_q;
    logic [NCH-1:0][CNT_W-1:0]  cnt_w;
    logic [NCH-1:0]             ien_q;
    logic [NCH-1:0]             ist_q;
    logic [NCH-1:0]             zero_w;
    logic [NCH-1:0]             tick_w;
    logic [NGRP-1:0]            pre_pulse;
    logic [NGRP-1:0][DIVW-1:0]  divcnt;
    logic                       int_wr;

    assign int_wr = we && (addr == A_INT);

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            dsel_q <= '0;
            ctl_q  <= '0;
            cntb_q <= '0;
            cmpb_q <= '0;
            ien_q  <= '0;
        end else if (we) begin
            if (addr == A_CFG0) pre_q  <= wdata[15:0];
            if (addr == A_CFG1) dsel_q <= wdata[19:0];
            if (addr == A_INT)  ien_q  <= wdata[NCH-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (addr == A_CTRL)       ctl_q[n]  <= ctl_unpack(wdata, n);
                if (addr == cntb_addr(n)) cntb_q[n] <= wdata[CNT_W-1:0];
                if ((n < NCH - 1) && (addr == cmpb_addr(n)))
                    cmpb_q[n] <= wdata[CNT_W-1:0];
            end
        end
    end

    // sticky status, set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst) ist_q <= '0;
        else     ist_q <= (ist_q & ~(int_wr ? wdata[2*NCH-1:NCH] : '0)) | zero_w;
    end

    assign irq = ist_q & ien_q;

    // read mux
    always_comb begin
        rdata = '0;
        if (addr == A_CFG0) rdata = {16'h0, pre_q};
        if (addr == A_CFG1) rdata = {12'h0, dsel_q};
        if (addr == A_INT)  rdata = {22'h0, ist_q, ien_q};
        for (int n = 0; n < NCH; n++) begin
            if (addr == A_CTRL)       rdata = rdata | ctl_pack(ctl_q[n], n);
            if (addr == cntb_addr(n)) rdata = 32'(cntb_q[n]);
            if ((n < NCH - 1) && (addr == cmpb_addr(n))) rdata = 32'(cmpb_q[n]);
            if (addr == obs_addr(n))  rdata = 32'(cnt_w[n]);
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_pre
        dct_prescale #(.PW(8), .DW(DIVW)) u_pre (
            .clk    (clk),
            .rst    (rst),
            .scale  (pre_q[g]),
            .pulse  (pre_pulse[g]),
            .divcnt (divcnt[g])
        );
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int G = grp_of(n);
        logic [DIVW-1:0] msk;

        assign msk       = div_mask(dsel_q[n], DIV_BASE);
        assign tick_w[n] = pre_pulse[G] && ((divcnt[G] & msk) == msk);

        dct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_w[n]),
            .ctl      (ctl_q[n]),
            .cntb     (cntb_q[n]),
            .cmpb     (cmpb_q[n]),
            .cnt      (cnt_w[n]),
            .zero_evt (zero_w[n]),
            .pwm      (pwm_out[n])
        );
    end
endmodule

// File: rtl/dct_timer_chk.sv
module dct_timer_chk
    import dct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      int_wr,
    input logic [NCH-1:0]            clr,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0][CNT_W-1:0] cntb,
    input chctl_t [NCH-1:0]          ctl,
    input logic [NCH-1:0]            ist
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $fell(rst) |-> (cnt == '0 && ist == '0)); // R1

    for (genvar n = 0; n < NCH; n++) begin : g_a
        AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (rst)
            ctl[n].manual |=> cnt[n] == $past(cntb[n])); // R6

        AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
            (ctl[n].start && !ctl[n].manual && cnt[n] != '0)
            |=> (cnt[n] == $past(cnt[n]) || cnt[n] == $past(cnt[n]) - 1'b1)); // R7

        AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (ctl[n].start && !ctl[n].manual && !ctl[n].reload && cnt[n] == '0)
            |=> cnt[n] == '0); // R7

        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ist[n] && !(int_wr && clr[n])) |=> ist[n]); // R9
    end
endmodule

bind dct_timer dct_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .int_wr (we && (addr == 8'h44)),
    .clr    (wdata[9:5]),
    .cnt    (cnt_w),
    .cntb   (cntb_q),
    .ctl    (ctl_q),
    .ist    (ist_q)
);

// File: tb/dct_timer_bench.sv
module dct_timer_bench;
    localparam int CW = 16;
    localparam int DB = 1;
    localparam int CMASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [4:0]  irq;
    logic [4:0]  pwm_out;

    always #5 clk = ~clk;

    dct_timer #(.CNT_W(CW), .DIV_BASE(DB)) u_dct_timer (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .irq(irq), .pwm_out(pwm_out)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_pre[2], m_pc[2], m_dc[2];
    int m_dsel[5], m_cntb[5], m_cmpb[5], m_cnt[5], m_cmp[5];
    int m_ctl, m_ien, m_ist;

    function automatic int cbit(int n, int k);
        int b;
        b = (n == 0) ? 0 : 4 * n + 4;
        if (k == 3 && n == 4) return (m_ctl >> (b + 2)) & 1;
        if (k == 2 && n == 4) return 0;
        return (m_ctl >> (b + k)) & 1;
    endfunction

    function automatic int model_rd(int a);
        if (a == 'h00) return m_pre[0] | (m_pre[1] << 8);
        if (a == 'h04) return m_dsel[0] | (m_dsel[1] << 4) | (m_dsel[2] << 8) |
                              (m_dsel[3] << 12) | (m_dsel[4] << 16);
        if (a == 'h08) return m_ctl;
        if (a == 'h44) return m_ien | (m_ist << 5);
        for (int n = 0; n < 5; n++) begin
            if (a == 12 + 12 * n) return m_cntb[n];
            if (n < 4 && a == 16 + 12 * n) return m_cmpb[n];
            if (a == ((n == 4) ? 'h40 : 20 + 12 * n)) return m_cnt[n];
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        int pulse[2];
        int tk, sh, mk, g, evt;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin m_pre[i] = 0; m_pc[i] = 0; m_dc[i] = 0; end
            for (int i = 0; i < 5; i++) begin
                m_dsel[i] = 0; m_cntb[i] = 0; m_cmpb[i] = 0; m_cnt[i] = 0; m_cmp[i] = 0;
            end
            m_ctl = 0; m_ien = 0; m_ist = 0;
        end else begin
            for (int i = 0; i < 2; i++) pulse[i] = (m_pc[i] >= m_pre[i]) ? 1 : 0;
            evt = 0;
            for (int n = 0; n < 5; n++) begin
                g  = (n < 2) ? 0 : 1;
                sh = m_dsel[n] + DB;
                if (sh > 4) sh = 4;
                mk = (1 << sh) - 1;
                tk = (pulse[g] == 1 && (m_dc[g] & mk) == mk) ? 1 : 0;
                if (cbit(n, 1) == 1) begin
                    m_cnt[n] = m_cntb[n]; m_cmp[n] = m_cmpb[n];
                end else if (cbit(n, 0) == 1 && tk == 1) begin
                    if (m_cnt[n] != 0) begin
                        if (m_cnt[n] == 1) evt = evt | (1 << n);
                        m_cnt[n] = m_cnt[n] - 1;
                    end else if (cbit(n, 3) == 1) begin
                        m_cnt[n] = m_cntb[n]; m_cmp[n] = m_cmpb[n];
                    end
                end
            end
            if (we && addr == 8'h44) m_ist = m_ist & ~((wdata >> 5) & 31);
            m_ist = m_ist | evt;
            for (int i = 0; i < 2; i++) begin
                if (pulse[i] == 1) begin m_pc[i] = 0; m_dc[i] = (m_dc[i] + 1) % 16; end
                else m_pc[i] = m_pc[i] + 1;
            end
            if (we) begin
                if (addr == 8'h00) begin m_pre[0] = wdata & 255; m_pre[1] = (wdata >> 8) & 255; end
                if (addr == 8'h04) for (int n = 0; n < 5; n++) m_dsel[n] = (wdata >> (4 * n)) & 15;
                if (addr == 8'h08) m_ctl = wdata & 'h7FFF0F;
                if (addr == 8'h44) m_ien = wdata & 31;
                for (int n = 0; n < 5; n++) begin
                    if (addr == 12 + 12 * n) m_cntb[n] = wdata & CMASK;
                    if (n < 4 && addr == 16 + 12 * n) m_cmpb[n] = wdata & CMASK;
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of outputs against the model
    always @(negedge clk) begin
        int ep, ei;
        if (!rst) begin
            #2;
            ep = 0;
            for (int n = 0; n < 5; n++)
                if (((m_cnt[n] > ((n < 4) ? m_cmp[n] : 0)) ? 1 : 0) != cbit(n, 2)) ep |= (1 << n);
            ei = m_ist & m_ien;
            chk("R11 pwm_out", pwm_out, ep);
            chk("R10 irq", irq, ei);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 8'(a); wdata = 32'(d); we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        addr = 8'(a); we = 1'b0;
        #1;
        chk(tag, rdata, model_rd(a));
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd('h00, "R1 cfg0"); rd('h04, "R1 cfg1"); rd('h08, "R1 ctrl");
        rd('h44, "R1 int"); rd('h14, "R1 obs0"); rd('h40, "R1 obs4");
        chk("R1 irq", irq, 0); chk("R1 pwm", pwm_out, 0);
        // R2: map and readback
        wr('h18, 'hABCD); rd('h18, "R2 cntb1");
        wr('h34, 'h1234); rd('h34, "R2 cmpb3");
        wr('h04, -1); rd('h04, "R2 cfg1");
        wr('h00, -1); rd('h00, "R2 cfg0");
        rd('h3C, "R2 cntb4"); rd('h50, "R2 unmapped");
        // R5: control layout, unused bits read 0
        wr('h08, -1); rd('h08, "R5 ctrl all");
        wr('h08, 0);
        wr('h00, 'h0201); wr('h04, 'h100);
        // channel 0 periodic: R3 R4 R7 R8
        wr('h0C, 5); wr('h10, 2); wr('h44, 1);
        wr('h08, 'h2); rd('h14, "R6 manual load");
        wr('h08, 'h9);
        for (int i = 0; i < 30; i++) rd('h14, "R3_R7 obs0 periodic");
        idle(20);
        rd('h44, "R9 status set");
        // R9: write-one-to-clear
        wr('h08, 0);
        wr('h44, 'h01); rd('h44, "R9 write zero keeps");
        wr('h44, 'h21); rd('h44, "R9 write one clears");
        // R4: capped divider code on channel 0
        wr('h04, 'hF); wr('h0C, 3); wr('h08, 'h2); wr('h08, 'h9);
        for (int i = 0; i < 70; i++) rd('h14, "R4 obs0 divide cap");
        wr('h08, 0);
        // R7: one-shot on channel 2
        wr('h04, 'h100); wr('h24, 3); wr('h28, 1); wr('h44, 'h4);
        wr('h08, 'h2000); wr('h08, 'h1000);
        for (int i = 0; i < 20; i++) rd('h2C, "R8 obs2");
        idle(60);
        rd('h2C, "R7 oneshot holds zero"); rd('h44, "R9 oneshot status");
        // R11: invert on channel 1
        wr('h18, 4); wr('h1C, 1); wr('h08, 'h200); wr('h08, 'hD00);
        idle(40);
        rd('h20, "R8 obs1");
        // channel 4: reload at bit 22, observation at 0x40
        wr('h3C, 2); wr('h08, 'h200000); wr('h08, 'h500000);
        for (int i = 0; i < 40; i++) rd('h40, "R5_R8 obs4 reload");
        // R5: nibble 1 and bit 23 ignored
        wr('h08, 'h8000F0); rd('h08, "R5 ignored bits");
        idle(5); rd('h40, "R5 ch4 stopped"); rd('h20, "R5 ch1 stopped");
        // R6: manual hold wins over start on channel 3
        wr('h30, 7); wr('h08, 'h30000);
        idle(30); rd('h38, "R6 manual hold");
        wr('h30, 9); rd('h38, "R6 manual reload");
        wr('h08, 0);
        idle(3);
        summary();
        $finish;
    end
endmodule